// File: doc/BRIEF.md
# Receive Lane Bring-Up Synchronizer

This block brings up one receive lane of a converter serial link. On every link clock it takes a 32-bit word of four already decoded octets, a control flag per octet and an error flag per octet. Octet lane 0 (bits 7:0) is the earliest in time. The block holds an active-low synchronization request output low until the lane shows a run of comma characters. It then confirms that the characters after the release decode cleanly. Next it finds the start-of-multiframe character that opens the alignment sequence, which may sit in any of the four octet lanes. From that point every later word is rotated so that it starts on the frame boundary.

While the alignment sequence runs, the block copies the fourteen configuration octets of the second multiframe into four 32-bit registers. Once four multiframes have passed, it raises a link-valid flag and presents the aligned user words. The multiframe length in frames and the frame length in octets are runtime inputs. Their product must be a multiple of four and at least 16.

Top module: `lsync_lane_rx`

## Requirements
- R1: After reset, `sync_n` is low and `cgs_done`, `frame_locked`, `link_valid` and `user_data` are all zero.
- R2: `sync_n` rises on the clock after the word that completes four consecutive comma octets (data 0xBC with the control flag set). The run may span word boundaries, and any other octet restarts the count.
- R3: An octet error flag on any word before the user data phase returns the block to the hunting state. `sync_n` is then low on the next clock and `cgs_done` and `frame_locked` are cleared.
- R4: One error-free word (four further characters) after the release, `cgs_done` rises.
- R5: After `cgs_done`, the first octet that is not a comma, at any lane position, must be the start-of-multiframe character (0x1C with the control flag). If it is, `frame_locked` rises on the next clock. If any other octet comes first, the block restarts with `sync_n` low.
- R6: Each output word is rotated so that octet lane 0 holds the octet that follows, by a multiple of four, the start-of-multiframe octet.
- R7: Octets 2 to 15 of the second multiframe (counted from its first octet) land in `ilas_cfg0`..`ilas_cfg3`, four per register, the earliest in bits 7:0. Bits 31:16 of `ilas_cfg3` read zero.
- R8: After `cfg_k * cfg_f` aligned words (four multiframes), `link_valid` rises together with the first user word. After that, one user word follows per clock in arrival order.
- R9: In the user data phase, octet error flags affect neither `link_valid` nor `sync_n`.
- R10: `cfg_k` and `cfg_f` set the multiframe size at run time, and with it both the capture window and the point at which the alignment sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 32 | Four decoded octets, lane 0 in bits 7:0 |
| rx_ctrl | input | 4 | Control-character flag per octet |
| rx_err | input | 4 | Code violation or disparity error per octet |
| cfg_k | input | KW | Frames per multiframe |
| cfg_f | input | FW | Octets per frame |
| sync_n | output | 1 | Active-low synchronization request |
| cgs_done | output | 1 | Code group synchronization complete |
| frame_locked | output | 1 | Start of multiframe found, lane realigned |
| link_valid | output | 1 | User data valid |
| user_data | output | 32 | Realigned user octets |
| user_ctrl | output | 4 | Realigned control flags |
| ilas_cfg0 | output | 32 | Configuration octets 0-3 |
| ilas_cfg1 | output | 32 | Configuration octets 4-7 |
| ilas_cfg2 | output | 32 | Configuration octets 8-11 |
| ilas_cfg3 | output | 32 | Configuration octets 12-13 |

## Verification
Four properties are checked on every cycle:
- An error before the data phase always drops the request on the next cycle.
- The request is never released off a word that carried an error or no control octet.
- Link-valid is sticky and implies lock.
- The alignment word counter stays below its runtime limit.

Some behaviours can only be shown by the bench's scenarios, which compare each output word against an octet stream the bench builds itself:
- the rotation for each start-of-multiframe lane position;
- the exact clock on which link-valid rises for a given K and F;
- the contents of the configuration registers;
- comma runs that straddle word boundaries.

// File: rtl/lsync_pkg.sv
// Shared constants and state encoding for the lane synchronizer.
// Assumes four octets per link word, lane 0 earliest.
package lsync_pkg;
    localparam int NOCT = 4;
    localparam int DW   = 8 * NOCT;
    localparam int IDXW = $clog2(NOCT);
    localparam logic [7:0] CH_COMMA    = 8'hBC;
    localparam logic [7:0] CH_MF_START = 8'h1C;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_VERIFY,
        ST_FRAME,
        ST_ALIGN_SEQ,
        ST_USER
    } lane_state_t;
endpackage

// File: rtl/lsync_scan.sv
// Combinational octet scanner: tracks the comma run across the word and
// finds the first non-comma octet. Assumes decoded octets with ctrl flags.
module lsync_scan
    import lsync_pkg::*;
(
    input  logic [DW-1:0]   data,
    input  logic [NOCT-1:0] ctrl,
    input  logic [2:0]      run_in,
    output logic            run_hit,
    output logic [2:0]      run_out,
    output logic            nonk_found,
    output logic [IDXW-1:0] nonk_idx,
    output logic            nonk_is_start
);
    logic [NOCT-1:0] is_comma;
    logic [NOCT-1:0] is_start;

    // Per-octet character classification.
    for (genvar g = 0; g < NOCT; g++) begin : g_cls
        assign is_comma[g] = ctrl[g] && (data[8*g +: 8] == CH_COMMA);
        assign is_start[g] = ctrl[g] && (data[8*g +: 8] == CH_MF_START);
    end

    // Walk the octets in time order, extending or clearing the comma run.
    always_comb begin
        logic [2:0] r;
        r       = run_in;
        run_hit = 1'b0;
        for (int i = 0; i < NOCT; i++) begin
            if (is_comma[i]) begin
                if (r < 3'd4) r = r + 3'd1;
                if (r == 3'd4) run_hit = 1'b1;
            end else begin
                r = 3'd0;
            end
        end
        run_out = r;
    end

    // Locate the earliest non-comma octet and classify it.
    always_comb begin
        nonk_found    = 1'b0;
        nonk_idx      = '0;
        nonk_is_start = 1'b0;
        for (int i = 0; i < NOCT; i++) begin
            if (!nonk_found && !is_comma[i]) begin
                nonk_found    = 1'b1;
                nonk_idx      = IDXW'(i);
                nonk_is_start = is_start[i];
            end
        end
    end
endmodule

// File: rtl/lsync_align.sv
// Octet realigner: keeps the previous word and rotates {current, previous}
// by the latched lane phase. Assumes phase is loaded on the word holding
// the start-of-multiframe octet.
module lsync_align
    import lsync_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   raw_data,
    input  logic [NOCT-1:0] raw_ctrl,
    input  logic            load,
    input  logic [IDXW-1:0] phase_in,
    output logic [DW-1:0]   al_data,
    output logic [NOCT-1:0] al_ctrl
);
    logic [DW-1:0]     prev_data;
    logic [NOCT-1:0]   prev_ctrl;
    logic [IDXW-1:0]   phase_q;
    logic [2*DW-1:0]   cat_data;
    logic [2*NOCT-1:0] cat_ctrl;

    // Hold one word of history for octets that straddle a word boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_data <= '0;
            prev_ctrl <= '0;
        end else begin
            prev_data <= raw_data;
            prev_ctrl <= raw_ctrl;
        end
    end

    // Latch the lane position of the start-of-multiframe octet.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase_q <= '0;
        else if (load) phase_q <= phase_in;
    end

    // Select four consecutive octets starting at the latched phase.
    always_comb begin
        cat_data = {raw_data, prev_data};
        cat_ctrl = {raw_ctrl, prev_ctrl};
        al_data  = cat_data[{phase_q, 3'b000} +: DW];
        al_ctrl  = cat_ctrl[phase_q +: NOCT];
    end
endmodule

// File: rtl/lsync_ilas.sv
// Alignment-sequence tracker: counts aligned words against the runtime
// length and captures the configuration octets of the second multiframe.
// Assumes total is a multiple of four and at least 16 words.
module lsync_ilas
    import lsync_pkg::*;
#(
    parameter int TW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          active,
    input  logic [DW-1:0] al_data,
    input  logic [TW-1:0] total,
    output logic          last,
    output logic [DW-1:0] cfg0,
    output logic [DW-1:0] cfg1,
    output logic [DW-1:0] cfg2,
    output logic [DW-1:0] cfg3
);
    localparam int HALF = DW / 2;

    logic [TW-1:0]        wcnt;
    logic [TW-1:0]        cap_base;
    logic [TW-1:0]        cap_off;
    logic                 in_window;
    logic [3:0][DW-1:0]   cap_q;

    assign cap_base  = total >> 2;
    assign cap_off   = wcnt - cap_base;
    assign in_window = (wcnt >= cap_base) && (wcnt < cap_base + TW'(4));
    assign last      = active && (wcnt == total - TW'(1));

    // Aligned word counter, cleared when the sequence begins.
    always_ff @(posedge clk) begin
        if (!rst_n)      wcnt <= '0;
        else if (start)  wcnt <= '0;
        else if (active) wcnt <= wcnt + TW'(1);
    end

    // Store the four words that open the second multiframe.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cap_q <= '0;
        else if (active && in_window)    cap_q[cap_off[1:0]] <= al_data;
    end

    // Drop the two leading control octets and repack in arrival order.
    assign cfg0 = {cap_q[1][HALF-1:0], cap_q[0][DW-1:HALF]};
    assign cfg1 = {cap_q[2][HALF-1:0], cap_q[1][DW-1:HALF]};
    assign cfg2 = {cap_q[3][HALF-1:0], cap_q[2][DW-1:HALF]};
    assign cfg3 = {{HALF{1'b0}},       cap_q[3][DW-1:HALF]};

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (wcnt < total));
endmodule

// File: rtl/lsync_lane_rx.sv
// Lane bring-up controller: comma hunt, post-release check, frame
// alignment, alignment-sequence capture and user data hand-off.
// Assumes cfg_k * cfg_f is a multiple of four and at least 16.
module lsync_lane_rx
    import lsync_pkg::*;
#(
    parameter int KW = 6,
    parameter int FW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     rx_data,
    input  logic [3:0]      rx_ctrl,
    input  logic [3:0]      rx_err,
    input  logic [KW-1:0]   cfg_k,
    input  logic [FW-1:0]   cfg_f,
    output logic            sync_n,
    output logic            cgs_done,
    output logic            frame_locked,
    output logic            link_valid,
    output logic [31:0]     user_data,
    output logic [3:0]      user_ctrl,
    output logic [31:0]     ilas_cfg0,
    output logic [31:0]     ilas_cfg1,
    output logic [31:0]     ilas_cfg2,
    output logic [31:0]     ilas_cfg3
);
    localparam int TW = KW + FW;

    lane_state_t     state_q, state_d;
    logic [2:0]      run_q, run_d, run_out;
    logic            run_hit, nonk_found, nonk_is_start;
    logic [IDXW-1:0] nonk_idx;
    logic            load, any_err, seq_last;
    logic [TW-1:0]   total;
    logic [DW-1:0]   al_data;
    logic [NOCT-1:0] al_ctrl;

    assign any_err = |rx_err;
    assign total   = TW'(cfg_k) * TW'(cfg_f);

    lsync_scan u_scan (
        .data(rx_data), .ctrl(rx_ctrl), .run_in(run_q),
        .run_hit(run_hit), .run_out(run_out),
        .nonk_found(nonk_found), .nonk_idx(nonk_idx),
        .nonk_is_start(nonk_is_start)
    );

    lsync_align u_align (
        .clk(clk), .rst_n(rst_n), .raw_data(rx_data), .raw_ctrl(rx_ctrl),
        .load(load), .phase_in(nonk_idx), .al_data(al_data), .al_ctrl(al_ctrl)
    );

    lsync_ilas #(.TW(TW)) u_ilas (
        .clk(clk), .rst_n(rst_n), .start(load),
        .active(state_q == ST_ALIGN_SEQ), .al_data(al_data), .total(total),
        .last(seq_last), .cfg0(ilas_cfg0), .cfg1(ilas_cfg1),
        .cfg2(ilas_cfg2), .cfg3(ilas_cfg3)
    );

    // Next-state decision for the bring-up sequence.
    always_comb begin
        state_d = state_q;
        run_d   = 3'd0;
        load    = 1'b0;
        case (state_q)
            ST_HUNT: begin
                if (!any_err) begin
                    if (run_hit) state_d = ST_VERIFY;
                    else         run_d   = run_out;
                end
            end
            ST_VERIFY: state_d = any_err ? ST_HUNT : ST_FRAME;
            ST_FRAME: begin
                if (any_err) state_d = ST_HUNT;
                else if (nonk_found) begin
                    if (nonk_is_start) begin
                        state_d = ST_ALIGN_SEQ;
                        load    = 1'b1;
                    end else begin
                        state_d = ST_HUNT;
                    end
                end
            end
            ST_ALIGN_SEQ: begin
                if (any_err)       state_d = ST_HUNT;
                else if (seq_last) state_d = ST_USER;
            end
            default: state_d = ST_USER;
        endcase
    end

    // State and comma-run registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            run_q   <= 3'd0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    // Registered user data stage, zero outside the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_valid <= 1'b0;
            user_data  <= '0;
            user_ctrl  <= '0;
        end else begin
            link_valid <= (state_q == ST_USER);
            user_data  <= (state_q == ST_USER) ? al_data : '0;
            user_ctrl  <= (state_q == ST_USER) ? al_ctrl : '0;
        end
    end

    assign sync_n       = (state_q != ST_HUNT);
    assign cgs_done     = (state_q == ST_FRAME) || (state_q == ST_ALIGN_SEQ) ||
                          (state_q == ST_USER);
    assign frame_locked = (state_q == ST_ALIGN_SEQ) || (state_q == ST_USER);

    p_err_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_USER) && any_err) |=> !sync_n);
    p_release_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n) |-> (!$past(any_err) && ($past(rx_ctrl) != 4'd0)));
    p_user_holds_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        link_valid |=> (link_valid && sync_n));
    p_valid_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        link_valid |-> (frame_locked && cgs_done));
endmodule

// File: tb/lsync_lane_rx_tb.sv
module lsync_lane_rx_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] rx_data = '0;
    logic [3:0]  rx_ctrl = '0;
    logic [3:0]  rx_err = '0;
    logic [5:0]  cfg_k = 6'd16;
    logic [4:0]  cfg_f = 5'd1;
    logic        sync_n, cgs_done, frame_locked, link_valid;
    logic [31:0] user_data, ilas_cfg0, ilas_cfg1, ilas_cfg2, ilas_cfg3;
    logic [3:0]  user_ctrl;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] s_d [0:2047];
    logic       s_c [0:2047];

    always #(CLK_PERIOD/2) clk = ~clk;

    lsync_lane_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
        .rx_err(rx_err), .cfg_k(cfg_k), .cfg_f(cfg_f), .sync_n(sync_n),
        .cgs_done(cgs_done), .frame_locked(frame_locked),
        .link_valid(link_valid), .user_data(user_data), .user_ctrl(user_ctrl),
        .ilas_cfg0(ilas_cfg0), .ilas_cfg1(ilas_cfg1),
        .ilas_cfg2(ilas_cfg2), .ilas_cfg3(ilas_cfg3)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] d, input logic [3:0] c, input logic [3:0] e);
        @(negedge clk);
        rx_data = d; rx_ctrl = c; rx_err = e;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rx_data = '0; rx_ctrl = '0; rx_err = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [31:0] oct4(input int q);
        return {s_d[q+3], s_d[q+2], s_d[q+1], s_d[q]};
    endfunction

    function automatic logic [3:0] ctl4(input int q);
        return {s_c[q+3], s_c[q+2], s_c[q+1], s_c[q]};
    endfunction

    // Full bring-up with a given K, F and number of leading comma octets.
    task automatic run_link(input int k, input int f, input int nk);
        int t, r, nw, q;
        t = k * f;
        for (int j = 0; j < 2048; j++) begin
            s_d[j] = 8'($urandom);
            s_c[j] = 1'b0;
        end
        for (int j = 0; j < nk; j++) begin
            s_d[j] = 8'hBC; s_c[j] = 1'b1;
        end
        for (int j = 0; j < 4 * t; j++) begin
            if (j % t == 0)          begin s_d[nk+j] = 8'h1C; s_c[nk+j] = 1'b1; end
            else if (j % t == t - 1) begin s_d[nk+j] = 8'h7C; s_c[nk+j] = 1'b1; end
            else if (j == t + 1)     begin s_d[nk+j] = 8'h9C; s_c[nk+j] = 1'b1; end
        end
        cfg_k = 6'(k); cfg_f = 5'(f);
        do_reset();
        r  = nk / 4;
        nw = r + t + 17;
        for (int i = 0; i < nw; i++) begin
            drive(oct4(4*i), ctl4(4*i), 4'd0);
            if (i == 0)     chk("R2 release after four commas", 32'(sync_n), 32'd1);
            if (i == 1)     chk("R4 cgs done one word after release", 32'(cgs_done), 32'd1);
            if (i == r - 1) chk("R5 no lock before start octet", 32'(frame_locked), 32'd0);
            if (i == r)     chk("R5 lock on start octet", 32'(frame_locked), 32'd1);
            chk("R8 R10 link_valid timing", 32'(link_valid), 32'(i >= r + t + 1));
            if (i >= r + t + 1) begin
                q = nk + 4*t + 4*(i - r - t - 1);
                chk("R6 realigned user word", user_data, oct4(q));
                chk("R6 realigned user ctrl", 32'(user_ctrl), 32'(ctl4(q)));
            end
        end
        q = nk + t + 2;
        chk("R7 cfg0", ilas_cfg0, oct4(q));
        chk("R7 cfg1", ilas_cfg1, oct4(q + 4));
        chk("R7 cfg2", ilas_cfg2, oct4(q + 8));
        chk("R7 cfg3", ilas_cfg3, {16'd0, s_d[q+13], s_d[q+12]});
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int kk [7] = '{16, 8, 4, 32, 20, 6, 5};
        int ff [7] = '{1, 2, 4, 1, 4, 4, 4};
        int sel;
        void'($urandom(32'd2024));

        // R1 reset state
        do_reset();
        chk("R1 sync_n low", 32'(sync_n), 32'd0);
        chk("R1 cgs_done low", 32'(cgs_done), 32'd0);
        chk("R1 frame_locked low", 32'(frame_locked), 32'd0);
        chk("R1 link_valid low", 32'(link_valid), 32'd0);
        chk("R1 user_data zero", user_data, 32'd0);

        // R2 comma run across word boundaries, broken runs restart
        do_reset();
        drive({8'h55, 8'hBC, 8'hBC, 8'hBC}, 4'b0111, 4'd0);
        chk("R2 broken run keeps request", 32'(sync_n), 32'd0);
        drive({8'hBC, 8'hBC, 8'hBC, 8'h55}, 4'b1110, 4'd0);
        chk("R2 three commas keep request", 32'(sync_n), 32'd0);
        drive({8'h55, 8'h55, 8'h55, 8'hBC}, 4'b0001, 4'd0);
        chk("R2 run spanning words releases", 32'(sync_n), 32'd1);
        // R3 error during post-release check
        drive(32'hBCBCBCBC, 4'hF, 4'b0100);
        chk("R3 error reasserts request", 32'(sync_n), 32'd0);
        chk("R3 error clears cgs_done", 32'(cgs_done), 32'd0);

        // R5 wrong first non-comma character
        do_reset();
        drive(32'hBCBCBCBC, 4'hF, 4'd0);
        drive(32'hBCBCBCBC, 4'hF, 4'd0);
        chk("R4 cgs done", 32'(cgs_done), 32'd1);
        drive({8'h55, 8'h55, 8'hBC, 8'hBC}, 4'b0011, 4'd0);
        chk("R5 wrong char restarts", 32'(sync_n), 32'd0);

        // R3 error during the alignment sequence
        do_reset();
        drive(32'hBCBCBCBC, 4'hF, 4'd0);
        drive(32'hBCBCBCBC, 4'hF, 4'd0);
        drive({8'h33, 8'h22, 8'h11, 8'h1C}, 4'b0001, 4'd0);
        chk("R5 lock at lane 0", 32'(frame_locked), 32'd1);
        drive(32'h01020304, 4'd0, 4'b0001);
        chk("R3 error in sequence reasserts", 32'(sync_n), 32'd0);
        chk("R3 error in sequence drops lock", 32'(frame_locked), 32'd0);

        // Directed phases then random K, F and phase
        for (int p = 0; p < 4; p++) run_link(4, 4, 8 + p);
        for (int n = 0; n < 8; n++) begin
            sel = int'($urandom % 7);
            run_link(kk[sel], ff[sel], 8 + int'($urandom % 12));
        end

        // R9 errors ignored in user phase
        drive(32'hDEADBEEF, 4'd0, 4'hF);
        chk("R9 link_valid kept", 32'(link_valid), 32'd1);
        chk("R9 sync_n kept", 32'(sync_n), 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule